// File: doc/BRIEF.md
# Pointer Tag Stripping Unit

This block cleans software tags out of 64-bit pointers ahead of address translation. Each incoming pointer is qualified by a valid strobe and a user/privileged flag. A small mode register chooses how the upper bits are read. Some layouts drop a group of high bits and refill them with copies of the highest bit that is kept. Others keep bit 63 as the sign, drop a band of bits below it, and require bit 63 to match the top retained address bit. A legacy layout treats the pointer as a 32-bit word holding a 24-bit address.

One clock after a valid input, the unit gives the cleaned address, the removed bits right-aligned on a 16-bit tag bus, and a fault flag. A fault comes from a failed equality or canonical check, or from a user-mode access to a high-half address. A faulting result carries an all-zero address. The mode register is written through a write strobe and applies only to inputs presented after the write.

Top module: `ptr_tag_mask`

## Requirements
- R1: After reset the mode register holds 0, and out_valid, out_fault, out_addr and out_tag are all 0.
- R2: out_valid is in_valid delayed by one clock. When out_valid is 0, out_addr, out_tag and out_fault keep their previous values.
- R3: Mode 0 (disabled) and the reserved code 7 pass the pointer through unchanged with tag 0. Bits 63..47 must be all equal; otherwise the fault flag is raised.
- R4: Mode 1 (legacy 24-bit) outputs pointer bits 23..0 zero-extended to 64 bits, with tag = pointer bits 31..24. Bits 63..32 are ignored.
- R5: Mode 2 ignores bits 63..56. The address is bit 55 and below, sign-extended from bit 55, and the tag is bits 63..56.
- R6: Mode 3 ignores bits 63..57. The address is sign-extended from bit 56, and the tag is bits 63..57.
- R7: Mode 4 keeps bit 63 and ignores bits 62..57, which are refilled with bit 63. The tag is bits 62..57. A fault is raised when bit 63 differs from bit 56.
- R8: Mode 5 keeps bit 63 and ignores bits 62..48, which are refilled with bit 63. The tag is bits 62..48. A fault is raised when bit 63 differs from bit 47.
- R9: Mode 6 ignores bits 63..48. The address is sign-extended from bit 47, and the tag is bits 63..48.
- R10: When in_user is 1 and the cleaned address has bit 63 set, a fault is raised.
- R11: Whenever out_fault is 1 on a valid output, out_addr is 0.
- R12: The tag is right-aligned on out_tag, and tag bits above the width for the mode are 0.
- R13: A value on cfg_mode written with cfg_we applies to inputs from the next clock onward. An input presented in the same cycle as the write uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pointer strobe |
| in_ptr | input | 64 | Tagged pointer |
| in_user | input | 1 | 1 = user privilege |
| cfg_we | input | 1 | Mode register write enable |
| cfg_mode | input | 3 | New mode value |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 64 | Cleaned address, 0 on fault |
| out_tag | output | 16 | Removed bits, right-aligned |
| out_fault | output | 1 | Fault flag |

## Verification
The bench targets the sign-bit equality in modes 4 and 5 with pointers that differ only in bit 56 or bit 47. A design that compares the wrong bit lets a mismatched pointer through or faults a good one. It writes the mode in the same cycle as a pointer whose tag byte would be non-canonical under the old mode. A design that applies the write early returns a masked address instead of a fault. User pointers that clean to high-half addresses test that the privilege check runs on the cleaned address, not the raw one, and that the address is zeroed when the check faults. Cycles with no valid input test that the outputs hold.

// File: rtl/ptr_tag_mask.sv
module ptr_tag_mask (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_ptr,
  input  logic        in_user,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_mode,
  output logic        out_valid,
  output logic [63:0] out_addr,
  output logic [15:0] out_tag,
  output logic        out_fault
);

  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_L24  = 3'd1;
  localparam logic [2:0] M_TB8  = 3'd2;
  localparam logic [2:0] M_TB7  = 3'd3;
  localparam logic [2:0] M_KS6  = 3'd4;
  localparam logic [2:0] M_KS15 = 3'd5;
  localparam logic [2:0] M_TB16 = 3'd6;

  logic [2:0]  mode_q;
  logic [63:0] addr_c;
  logic [15:0] tag_c;
  logic        bad_c;
  logic        fault_c;

  wire p63 = in_ptr[63];
  wire canon47 = (in_ptr[63:47] == '0) || (in_ptr[63:47] == '1);

  always_comb begin
    addr_c = in_ptr;
    tag_c  = '0;
    bad_c  = 1'b0;
    case (mode_q)
      M_L24: begin
        addr_c = {40'd0, in_ptr[23:0]};
        tag_c  = {8'd0, in_ptr[31:24]};
      end
      M_TB8: begin
        addr_c = {{8{in_ptr[55]}}, in_ptr[55:0]};
        tag_c  = {8'd0, in_ptr[63:56]};
      end
      M_TB7: begin
        addr_c = {{7{in_ptr[56]}}, in_ptr[56:0]};
        tag_c  = {9'd0, in_ptr[63:57]};
      end
      M_KS6: begin
        addr_c = {{7{p63}}, in_ptr[56:0]};
        tag_c  = {10'd0, in_ptr[62:57]};
        bad_c  = p63 != in_ptr[56];
      end
      M_KS15: begin
        addr_c = {{16{p63}}, in_ptr[47:0]};
        tag_c  = {1'b0, in_ptr[62:48]};
        bad_c  = p63 != in_ptr[47];
      end
      M_TB16: begin
        addr_c = {{16{in_ptr[47]}}, in_ptr[47:0]};
        tag_c  = in_ptr[63:48];
      end
      default: begin
        bad_c = !canon47;
      end
    endcase
  end

  assign fault_c = bad_c || (in_user && addr_c[63]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_tag   <= '0;
      out_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= fault_c ? 64'd0 : addr_c;
        out_tag   <= tag_c;
        out_fault <= fault_c;
      end
    end
  end

endmodule

module ptr_tag_mask_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_user,
  input logic [2:0]  mode_q,
  input logic        out_valid,
  input logic [63:0] out_addr,
  input logic [15:0] out_tag,
  input logic        out_fault
);

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_addr) && $stable(out_tag) && $stable(out_fault)); // R2

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> out_addr == 64'd0); // R11

  AST_USER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_user |=> !out_addr[63]); // R10

  AST_LEGACY_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_q == 3'd1 |=> out_addr[63:24] == '0 && out_tag[15:8] == '0); // R4

  AST_TAG6_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_q == 3'd4 |=> out_tag[15:6] == '0); // R12

  AST_WIDE_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (mode_q == 3'd0 || mode_q == 3'd5 || mode_q == 3'd6)
    |=> out_addr[63:47] == '0 || out_addr[63:47] == '1); // R3

endmodule

bind ptr_tag_mask ptr_tag_mask_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_user(in_user),
  .mode_q(mode_q), .out_valid(out_valid), .out_addr(out_addr),
  .out_tag(out_tag), .out_fault(out_fault)
);

// File: tb/ptr_tag_mask_test.sv
module ptr_tag_mask_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_ptr;
  logic        in_user;
  logic        cfg_we;
  logic [2:0]  cfg_mode;
  logic        out_valid;
  logic [63:0] out_addr;
  logic [15:0] out_tag;
  logic        out_fault;

  int tests = 0;
  int fails = 0;
  logic [2:0]  mode_m;
  logic [63:0] hold_addr;
  logic [15:0] hold_tag;
  logic        hold_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_tag_mask uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ptr(in_ptr),
    .in_user(in_user), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .out_valid(out_valid), .out_addr(out_addr), .out_tag(out_tag),
    .out_fault(out_fault)
  );

  function automatic logic [80:0] expect_of(input logic [2:0] m, input logic [63:0] p, input logic u);
    logic [63:0] a;
    logic [15:0] t;
    logic bad;
    logic f;
    a = p; t = '0; bad = 1'b0;
    case (m)
      3'd1: begin a = {40'd0, p[23:0]}; t = {8'd0, p[31:24]}; end
      3'd2: begin a = {{8{p[55]}}, p[55:0]}; t = {8'd0, p[63:56]}; end
      3'd3: begin a = {{7{p[56]}}, p[56:0]}; t = {9'd0, p[63:57]}; end
      3'd4: begin a = {{7{p[63]}}, p[56:0]}; t = {10'd0, p[62:57]}; bad = p[63] != p[56]; end
      3'd5: begin a = {{16{p[63]}}, p[47:0]}; t = {1'b0, p[62:48]}; bad = p[63] != p[47]; end
      3'd6: begin a = {{16{p[47]}}, p[47:0]}; t = p[63:48]; end
      default: bad = !((p[63:47] == '0) || (p[63:47] == '1));
    endcase
    f = bad || (u && a[63]);
    if (f) a = '0;
    return {f, t, a};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [63:0] p, input logic u,
                       input logic we, input logic [2:0] m, input string req);
    logic [80:0] e;
    in_valid = v; in_ptr = p; in_user = u; cfg_we = we; cfg_mode = m;
    e = expect_of(mode_m, p, u);
    if (we) mode_m = m;
    @(negedge clk);
    check(out_valid == v, req, {63'd0, out_valid}, {63'd0, v});
    if (v) begin
      hold_addr = e[63:0]; hold_tag = e[79:64]; hold_fault = e[80];
    end
    check(out_addr == hold_addr, req, out_addr, hold_addr);
    check(out_tag == hold_tag, req, {48'd0, out_tag}, {48'd0, hold_tag});
    check(out_fault == hold_fault, req, {63'd0, out_fault}, {63'd0, hold_fault});
    in_valid = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7211));
    rst_n = 1'b0; in_valid = 1'b0; in_ptr = '0; in_user = 1'b0;
    cfg_we = 1'b0; cfg_mode = '0; mode_m = 3'd0;
    hold_addr = '0; hold_tag = '0; hold_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 1'b0 && out_fault == 1'b0, "R1", {63'd0, out_valid}, 64'd0);
    check(out_addr == 64'd0 && out_tag == 16'd0, "R1", out_addr, 64'd0);

    // R1 and R3: reset mode 0 passes canonical, faults on noncanonical
    cycle(1, 64'hFFFF_8000_1234_5678, 0, 0, 0, "R1");
    cycle(1, 64'h0001_0000_0000_0040, 0, 0, 0, "R3");
    // R13: write mode 2 with a tagged pointer in the same cycle -> old mode faults
    cycle(1, 64'hA500_1234_5678_9ABC, 0, 1, 2, "R13");
    cycle(1, 64'hA500_1234_5678_9ABC, 0, 0, 0, "R13");
    // R2: idle holds
    cycle(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, "R2");
    // R5
    cycle(1, 64'h3C80_0000_0000_0001, 0, 0, 0, "R5");
    // R4
    cycle(1, 64'h0000_0000_0000_0000, 0, 1, 1, "R4");
    cycle(1, 64'hDEAD_BEEF_7F12_3456, 1, 0, 0, "R4");
    // R6
    cycle(1, 64'h0000_0000_0000_0000, 0, 1, 3, "R6");
    cycle(1, 64'hFF00_0000_0000_0000, 0, 0, 0, "R6");
    cycle(1, 64'hFF00_0000_0000_0000, 1, 0, 0, "R10");
    // R7 match and mismatch
    cycle(1, 64'h0, 0, 1, 4, "R7");
    cycle(1, 64'h8100_0000_0000_0010, 0, 0, 0, "R7");
    cycle(1, 64'h8000_0000_0000_0010, 0, 0, 0, "R7");
    cycle(1, 64'h7F00_0000_0000_0010, 0, 0, 0, "R12");
    // R8
    cycle(1, 64'h0, 0, 1, 5, "R8");
    cycle(1, 64'hFFFF_8000_0000_0001, 0, 0, 0, "R8");
    cycle(1, 64'h8000_7FFF_0000_0001, 0, 0, 0, "R8");
    cycle(1, 64'hFFFF_8000_0000_0001, 1, 0, 0, "R11");
    // R9
    cycle(1, 64'h0, 0, 1, 6, "R9");
    cycle(1, 64'h1234_8000_0000_0000, 0, 0, 0, "R9");
    cycle(1, 64'h1234_8000_0000_0000, 1, 0, 0, "R10");
    // R3 reserved code 7
    cycle(1, 64'h0, 0, 1, 7, "R3");
    cycle(1, 64'h0000_7FFF_FFFF_FFFF, 0, 0, 0, "R3");
    cycle(1, 64'h0000_8000_0000_0000, 0, 0, 0, "R3");

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] p;
      logic [2:0] sel;
      p = {$urandom, $urandom};
      sel = 3'($urandom % 4);
      if (sel == 0) p[63:47] = {17{p[47]}};
      if (sel == 1) p[63] = p[56];
      if (sel == 2) p[63] = p[47];
      cycle(1'($urandom % 5 != 0), p, 1'($urandom), 1'($urandom % 7 == 0),
            3'($urandom), "R12");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule